// File: doc/BRIEF.md
# Double-Buffered Display Register Commit Controller

This block holds two copies of the display configuration: one shared general register, one register per overlay window and one cursor register. Software always writes the staging copy. The pixel pipeline sees only the live copy, which the block drives on its output ports. A staged value moves into the live copy only at a vertical-blank strobe, and only for a group that software has both armed and asked to activate. This means a frame never shows a half-written setup.

Per-window writes go to every window picked in a one-hot window-select register. Reads of a configuration register return the staging copy by default. When the live-view bit is set, the same addresses return the live copy instead. The block also has an interrupt unit. It latches vblank, frame-end and per-window underflow and overflow events, lets software clear them by writing ones, and raises an interrupt line. That line is gated by two separate per-source registers, a mask and an enable.

Top module: `commit_regs`

## Requirements
- R1: After reset, every live output, every staging register, the commit control readback, the interrupt status and the interrupt line are zero.
- R2: Address 0x1 holds a one-hot window select: bit i picks window i. A write to address 0x9 loads every selected window's staging register. A read of 0x9 returns the lowest-numbered selected window.
- R3: The commit control register at address 0x0 has arm bits and activate bits. Arm bits are bit 0 for general, bit 1+i for window i and bit 1+NWIN for the cursor. Activate bits are the same positions plus 8. A group with only its arm bit or only its activate bit pending does not transfer at vblank.
- R4: On a vblank strobe, each group that has both bits pending copies its staging value to its live output on that clock edge. Other groups are unaffected.
- R5: Live outputs change only on a clock edge where vblank is high.
- R6: Arm and activate bits written with ones read back as 1 until their group transfers. Both then read 0.
- R7: When bit 0 of address 0x2 is 1, reads of 0x8 (general), 0x9 (window) and 0xA (cursor) return the live copy. When it is 0, they return the staging copy.
- R8: A staging write in the same cycle as that group's transfer leaves the old staging value in the live copy and keeps the new value in staging.
- R9: The interrupt status at 0x3 latches events from the strobes. The bit layout is: bit 0 vblank, bit 1 frame-end, bits 2..2+NWIN-1 underflow of window i, and the next NWIN bits overflow of window i. Writing a 1 to a status bit clears it, and a 0 leaves it unchanged.
- R10: `irq` is high when some status bit has its mask bit (address 0x4) and its enable bit (address 0x5) both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| vblank | input | 1 | Vertical-blank strobe; commit point |
| frame_end | input | 1 | Frame-end strobe |
| win_uflow | input | NWIN | Per-window underflow strobes |
| win_oflow | input | NWIN | Per-window overflow strobes |
| gen_active | output | DW | Live general configuration |
| win_active | output | NWIN*DW | Live window configurations, window i at bits i*DW |
| cur_active | output | DW | Live cursor configuration |
| irq | output | 1 | Interrupt request |

## Verification
Commits are tried in four ways: with the arm bit alone, with the activate bit alone, with both bits, and with both bits on one window while its neighbours stay idle. These cases separate a correct two-condition gate from gates that need only one bit, or that leak into other groups. Window writes and reads are run with single and multiple select bits, which checks the write fan-out and the lowest-index read priority. A staging write placed on the vblank edge itself shows whether the live copy takes the old value. Interrupt sequences change the mask, the enable and partial write-one clears one at a time, so that each gate term and each status bit is seen alone.

// File: rtl/commit_regs.sv
module commit_regs #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int NWIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              vblank,
  input  logic              frame_end,
  input  logic [NWIN-1:0]   win_uflow,
  input  logic [NWIN-1:0]   win_oflow,
  output logic [DW-1:0]     gen_active,
  output logic [NWIN*DW-1:0] win_active,
  output logic [DW-1:0]     cur_active,
  output logic              irq
);
  localparam int NG      = NWIN + 2;
  localparam int NI      = 2 + 2 * NWIN;
  localparam int ACT_OFS = 8;
  localparam int CUR_G   = NWIN + 1;

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_WSEL = AW'(1);
  localparam logic [AW-1:0] A_VIEW = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_ENA  = AW'(5);
  localparam logic [AW-1:0] A_GEN  = AW'(8);
  localparam logic [AW-1:0] A_WIN  = AW'(9);
  localparam logic [AW-1:0] A_CUR  = AW'(10);

  logic [NG-1:0]   armed, pend, fire;
  logic [NWIN-1:0] wsel;
  logic            live_view;
  logic [DW-1:0]   gen_stg, cur_stg;
  logic [DW-1:0]   win_stg [NWIN];
  logic [NI-1:0]   istat, imask, iena, isrc;
  logic [DW-1:0]   win_rd, ctrl_rd;

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire wr_gen  = bus_wr && (bus_addr == A_GEN);
  wire wr_win  = bus_wr && (bus_addr == A_WIN);
  wire wr_cur  = bus_wr && (bus_addr == A_CUR);

  assign fire = vblank ? (armed & pend) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= '0;
      pend  <= '0;
      wsel  <= '0;
      live_view <= 1'b0;
      imask <= '0;
      iena  <= '0;
    end else begin
      armed <= (armed & ~fire) | (wr_ctrl ? bus_wdata[NG-1:0] : '0);
      pend  <= (pend  & ~fire) | (wr_ctrl ? bus_wdata[ACT_OFS +: NG] : '0);
      if (bus_wr && bus_addr == A_WSEL) wsel <= bus_wdata[NWIN-1:0];
      if (bus_wr && bus_addr == A_VIEW) live_view <= bus_wdata[0];
      if (bus_wr && bus_addr == A_MASK) imask <= bus_wdata[NI-1:0];
      if (bus_wr && bus_addr == A_ENA)  iena  <= bus_wdata[NI-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_stg <= '0;
      gen_active <= '0;
      cur_stg <= '0;
      cur_active <= '0;
    end else begin
      if (wr_gen) gen_stg <= bus_wdata;
      if (fire[0]) gen_active <= gen_stg;
      if (wr_cur) cur_stg <= bus_wdata;
      if (fire[CUR_G]) cur_active <= cur_stg;
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_stg[w] <= '0;
        win_active[w*DW +: DW] <= '0;
      end else begin
        if (wr_win && wsel[w]) win_stg[w] <= bus_wdata;
        if (fire[1+w]) win_active[w*DW +: DW] <= win_stg[w];
      end
    end
  end

  always_comb begin
    win_rd = '0;
    for (int w = NWIN - 1; w >= 0; w--)
      if (wsel[w]) win_rd = live_view ? win_active[w*DW +: DW] : win_stg[w];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[NG-1:0] = armed;
    ctrl_rd[ACT_OFS +: NG] = pend;
  end

  assign isrc = {win_oflow, win_uflow, frame_end, vblank};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) istat <= '0;
    else istat <= (istat & ~(wr_stat ? bus_wdata[NI-1:0] : '0)) | isrc;
  end

  assign irq = |(istat & imask & iena);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_rd;
      A_WSEL:  bus_rdata = DW'(wsel);
      A_VIEW:  bus_rdata = DW'(live_view);
      A_STAT:  bus_rdata = DW'(istat);
      A_MASK:  bus_rdata = DW'(imask);
      A_ENA:   bus_rdata = DW'(iena);
      A_GEN:   bus_rdata = live_view ? gen_active : gen_stg;
      A_WIN:   bus_rdata = win_rd;
      A_CUR:   bus_rdata = live_view ? cur_active : cur_stg;
      default: bus_rdata = '0;
    endcase
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> ($stable(gen_active) && $stable(cur_active) && $stable(win_active)));

  assert_arm_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !pend[0]) |=> $stable(gen_active));

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && armed[0] && pend[0] && !wr_ctrl) |=> (!armed[0] && !pend[0]));

  assert_stat_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> istat[0]);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && !frame_end) |=> !istat[1]);
endmodule

// File: tb/tb_commit_regs.sv
`timescale 1ns/100ps
module tb_commit_regs;
  localparam int DW = 32, AW = 4, NWIN = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic vblank = 1'b0, frame_end = 1'b0;
  logic [NWIN-1:0] win_uflow = '0, win_oflow = '0;
  logic [DW-1:0] gen_active, cur_active;
  logic [NWIN*DW-1:0] win_active;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  commit_regs #(.DW(DW), .AW(AW), .NWIN(NWIN)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank(vblank),
    .frame_end(frame_end), .win_uflow(win_uflow), .win_oflow(win_oflow),
    .gen_active(gen_active), .win_active(win_active), .cur_active(cur_active),
    .irq(irq));

  // {req[3:0], op[1:0] (0 write,1 read,2 vblank), addr[3:0], data[31:0]}
  localparam int NV = 45;
  localparam logic [41:0] VEC [NV] = '{
    {4'd7, 2'd0, 4'h8, 32'hAAAA0001},
    {4'd7, 2'd0, 4'h2, 32'h1},
    {4'd7, 2'd1, 4'h8, 32'h0},          // R7 live copy still empty
    {4'd6, 2'd0, 4'h0, 32'h1},
    {4'd6, 2'd1, 4'h0, 32'h1},          // R6 arm reads back
    {4'd3, 2'd2, 4'h0, 32'h0},
    {4'd3, 2'd1, 4'h8, 32'h0},          // R3 arm only: no transfer
    {4'd3, 2'd1, 4'h0, 32'h1},
    {4'd6, 2'd0, 4'h0, 32'h100},
    {4'd6, 2'd1, 4'h0, 32'h101},        // R6 both pending
    {4'd4, 2'd2, 4'h0, 32'h0},
    {4'd4, 2'd1, 4'h8, 32'hAAAA0001},   // R4 transfer
    {4'd6, 2'd1, 4'h0, 32'h0},          // R6 cleared
    {4'd7, 2'd0, 4'h2, 32'h0},
    {4'd7, 2'd1, 4'h8, 32'hAAAA0001},   // R7 staging view
    {4'd2, 2'd0, 4'h1, 32'h2},
    {4'd2, 2'd0, 4'h9, 32'hBBBB0002},
    {4'd2, 2'd0, 4'h1, 32'h4},
    {4'd2, 2'd0, 4'h9, 32'hCCCC0003},
    {4'd2, 2'd1, 4'h9, 32'hCCCC0003},   // R2 window C
    {4'd2, 2'd0, 4'h1, 32'h2},
    {4'd2, 2'd1, 4'h9, 32'hBBBB0002},   // R2 window B untouched by C write
    {4'd4, 2'd0, 4'h0, 32'h404},
    {4'd4, 2'd2, 4'h0, 32'h0},
    {4'd4, 2'd0, 4'h2, 32'h1},
    {4'd4, 2'd1, 4'h9, 32'hBBBB0002},   // R4 window B live
    {4'd4, 2'd0, 4'h1, 32'h4},
    {4'd4, 2'd1, 4'h9, 32'h0},          // R4 window C not committed
    {4'd2, 2'd0, 4'h1, 32'h6},
    {4'd2, 2'd1, 4'h9, 32'hBBBB0002},   // R2 lowest selected wins
    {4'd4, 2'd0, 4'hA, 32'hDDDD0004},
    {4'd6, 2'd0, 4'h0, 32'h1010},
    {4'd6, 2'd1, 4'h0, 32'h1010},
    {4'd4, 2'd2, 4'h0, 32'h0},
    {4'd4, 2'd1, 4'hA, 32'hDDDD0004},   // R4 cursor
    {4'd6, 2'd1, 4'h0, 32'h0},
    {4'd3, 2'd0, 4'h1, 32'h4},
    {4'd3, 2'd0, 4'h0, 32'h800},
    {4'd3, 2'd2, 4'h0, 32'h0},
    {4'd3, 2'd1, 4'h9, 32'h0},          // R3 activate only: no transfer
    {4'd3, 2'd1, 4'h0, 32'h800},
    {4'd4, 2'd0, 4'h0, 32'h8},
    {4'd4, 2'd2, 4'h0, 32'h0},
    {4'd4, 2'd1, 4'h9, 32'hCCCC0003},
    {4'd6, 2'd1, 4'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic vb();
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1 gen_active", gen_active, '0);
    chk("R1 cur_active", cur_active, '0);
    chk("R1 win_active", win_active[DW-1:0] | win_active[2*DW-1:DW] | win_active[3*DW-1:2*DW], '0);
    chk("R1 irq", DW'(irq), '0);
    rd("R1 ctrl", 4'h0, 32'h0);
    rd("R1 status", 4'h3, 32'h0);
    rd("R1 gen staging", 4'h8, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][37:36])
        2'd0: wr(VEC[i][35:32], VEC[i][31:0]);
        2'd1: rd($sformatf("R%0d vec%0d", VEC[i][41:38], i), VEC[i][35:32], VEC[i][31:0]);
        default: vb();
      endcase
    end

    #1 chk("R4 win_active B port", win_active[DW +: DW], 32'hBBBB0002);
    chk("R4 cur_active port", cur_active, 32'hDDDD0004);

    // R8 staging write on the transfer edge
    wr(4'h8, 32'h11110000);
    wr(4'h0, 32'h101);
    @(negedge clk);
    vblank = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h22220000;
    @(negedge clk);
    vblank = 1'b0; bus_wr = 1'b0;
    #1 chk("R8 live takes old", gen_active, 32'h11110000);
    wr(4'h2, 32'h0);
    rd("R8 staging keeps new", 4'h8, 32'h22220000);
    wr(4'h2, 32'h1);
    rd("R5 live unchanged", 4'h8, 32'h11110000);

    // R9 / R10 interrupts
    wr(4'h3, 32'hFF);
    rd("R9 all cleared", 4'h3, 32'h0);
    @(negedge clk); win_uflow = 3'b010;
    @(negedge clk); win_uflow = '0;
    rd("R9 underflow B bit3", 4'h3, 32'h08);
    chk("R10 irq no mask", DW'(irq), 32'h0);
    wr(4'h4, 32'h08);
    #1 chk("R10 irq mask only", DW'(irq), 32'h0);
    wr(4'h5, 32'h08);
    #1 chk("R10 irq mask+enable", DW'(irq), 32'h1);
    wr(4'h3, 32'h08);
    rd("R9 w1c", 4'h3, 32'h0);
    chk("R10 irq after clear", DW'(irq), 32'h0);
    @(negedge clk); vblank = 1'b1; frame_end = 1'b1;
    @(negedge clk); vblank = 1'b0; frame_end = 1'b0;
    rd("R9 vblank+frame_end", 4'h3, 32'h03);
    wr(4'h3, 32'h01);
    rd("R9 partial clear", 4'h3, 32'h02);
    @(negedge clk); win_oflow = 3'b100;
    @(negedge clk); win_oflow = '0;
    rd("R9 overflow C bit7", 4'h3, 32'h82);
    chk("R10 irq unmasked sources", DW'(irq), 32'h0);

    finish_run();
  end
endmodule